// File: doc/BRIEF.md
# Burst Address Sequencer with Suspend

This block produces the word address for a synchronous burst memory. On each rising clock edge it picks one of four actions: load a fresh external address, step to the next word of a four-word burst, hold the current word, or drop into the deselected state. The choice is driven by two active-low load strobes, an active-low advance input and three chip enables. The two strobes differ in how they treat the enables: the processor-side strobe is only honoured when the primary enable is active, while the controller-side strobe is only honoured when the processor-side strobe is not.

During a burst only the lowest `BURST_BITS` address bits move. A start offset register and a separate beat counter hold the burst state. The output offset is their sum in linear order, or their XOR in interleaved order. An order input selects between the two at run time, or a parameter can fix one order. After four beats the burst returns to its starting word. Holding advance high suspends the burst at the current word for as long as needed.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset drives `cur_addr` to 0, `desel` to 1 and `cyc_valid` to 0 after the next clock edge.
- R2: The processor strobe low, `en_main_n` low, `en_aux_hi` high and `en_aux_lo_n` low loads `ext_addr`. The next cycle shows `cur_addr == ext_addr`, `cyc_valid = 1` and `desel = 0`.
- R3: The processor strobe low with `en_main_n` low, but with either auxiliary enable inactive, deselects. The next cycle shows `desel = 1` and `cyc_valid = 0`.
- R4: While `en_main_n` is high, the processor strobe is ignored. If the controller strobe is also low, the cycle deselects. If the controller strobe is high, the edge acts as a step or hold according to `adv_n`.
- R5: The controller strobe low with the processor strobe high, and all three enables active, loads `ext_addr` exactly as in R2.
- R6: The controller strobe low with the processor strobe high, `en_main_n` low and either auxiliary enable inactive, deselects.
- R7: With no strobe in effect, `adv_n` low and the block selected, the address steps to the next burst word. Only the low `BURST_BITS` bits may change, and `cyc_valid` is 1.
- R8: With no strobe in effect and `adv_n` high, the address is held and `cyc_valid` is 0. `desel` is unchanged.
- R9: In linear order (`order_ilv` = 0), beat n of a burst has low bits equal to (start + n) mod 4. A start of 01 gives 01, 10, 11, 00, and a fifth step returns to 01.
- R10: In interleaved order (`order_ilv` = 1), beat n of a burst has low bits equal to start XOR n. A start of 10 gives 10, 11, 00, 01.
- R11: On step and hold edges the three enables are not sampled. Any enable values give the same result.
- R12: A step edge while deselected leaves `cur_addr` unchanged, keeps `desel` at 1 and gives `cyc_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | ADDR_W | External address offered for loading |
| proc_stb_n | input | 1 | Processor-side load strobe, active low |
| ctrl_stb_n | input | 1 | Controller-side load strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high suspends |
| en_main_n | input | 1 | Primary chip enable, active low |
| en_aux_hi | input | 1 | Secondary chip enable, active high |
| en_aux_lo_n | input | 1 | Secondary chip enable, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| cur_addr | output | ADDR_W | Current word address |
| cyc_valid | output | 1 | A load or a step took place on the last edge |
| desel | output | 1 | Sequencer is deselected |

## Verification
A wrong start-offset or beat-count register shows on `cur_addr` in the cycle right after the faulty edge. A count that fails to wrap, or that wraps early, shows within four steps of a load. A wrongly decoded enable priority shows on `desel` and `cyc_valid` one cycle after the strobe. A deselect flag that does not stick shows on the next step edge as an address change. The random sequences mix loads, steps, suspends and enable noise, so that such faults appear within a few cycles in both burst orders.

// File: rtl/burst_addr_seq_pkg.sv
package burst_addr_seq_pkg;
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_STEP  = 2'd1,
      OP_LOAD  = 2'd2,
      OP_DESEL = 2'd3
   } seq_op_e;

   localparam int ORDER_RUNTIME = 0;
   localparam int ORDER_LINEAR  = 1;
   localparam int ORDER_XOR     = 2;
endpackage

// File: rtl/bas_cmd_decode.sv
module bas_cmd_decode
   import burst_addr_seq_pkg::*;
(
   input  logic    proc_stb_n,
   input  logic    ctrl_stb_n,
   input  logic    adv_n,
   input  logic    en_main_n,
   input  logic    en_aux_hi,
   input  logic    en_aux_lo_n,
   output seq_op_e op
);
   logic aux_ok;
   logic proc_take;

   assign aux_ok    = en_aux_hi & ~en_aux_lo_n;
   assign proc_take = ~proc_stb_n & ~en_main_n;

   always_comb begin
      if (proc_take) begin
         op = aux_ok ? OP_LOAD : OP_DESEL;
      end else if (!ctrl_stb_n) begin
         op = (!en_main_n && aux_ok) ? OP_LOAD : OP_DESEL;
      end else if (!adv_n) begin
         op = OP_STEP;
      end else begin
         op = OP_HOLD;
      end
   end
endmodule

// File: rtl/bas_beat_reg.sv
module bas_beat_reg
   import burst_addr_seq_pkg::*;
#(
   parameter int ADDR_W     = 18,
   parameter int BURST_BITS = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  seq_op_e               op,
   input  logic [ADDR_W-1:0]     ext_addr,
   output logic [ADDR_W-1:0]     base_q,
   output logic [BURST_BITS-1:0] beat_q,
   output logic                  desel_q,
   output logic                  valid_q
);
   localparam logic [BURST_BITS-1:0] BEAT_ONE = BURST_BITS'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q  <= '0;
         beat_q  <= '0;
         desel_q <= 1'b1;
         valid_q <= 1'b0;
      end else begin
         unique case (op)
            OP_LOAD: begin
               base_q  <= ext_addr;
               beat_q  <= '0;
               desel_q <= 1'b0;
               valid_q <= 1'b1;
            end
            OP_DESEL: begin
               desel_q <= 1'b1;
               valid_q <= 1'b0;
            end
            OP_STEP: begin
               if (!desel_q) begin
                  beat_q  <= beat_q + BEAT_ONE;
                  valid_q <= 1'b1;
               end else begin
                  valid_q <= 1'b0;
               end
            end
            default: begin
               valid_q <= 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
   import burst_addr_seq_pkg::*;
#(
   parameter int BURST_BITS = 2,
   parameter int ORDER_SEL  = ORDER_RUNTIME
) (
   input  logic [BURST_BITS-1:0] start_lo,
   input  logic [BURST_BITS-1:0] beat,
   input  logic                  order_ilv,
   output logic [BURST_BITS-1:0] word_lo
);
   logic [BURST_BITS-1:0] lin_lo;
   logic [BURST_BITS-1:0] xor_lo;

   assign lin_lo = start_lo + beat;
   assign xor_lo = start_lo ^ beat;

   generate
      if (ORDER_SEL == ORDER_LINEAR) begin : g_lin
         assign word_lo = lin_lo;
      end else if (ORDER_SEL == ORDER_XOR) begin : g_xor
         assign word_lo = xor_lo;
      end else begin : g_rt
         assign word_lo = order_ilv ? xor_lo : lin_lo;
      end
   endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_addr_seq_pkg::*;
#(
   parameter int ADDR_W     = 18,
   parameter int BURST_BITS = 2,
   parameter int ORDER_SEL  = ORDER_RUNTIME
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              proc_stb_n,
   input  logic              ctrl_stb_n,
   input  logic              adv_n,
   input  logic              en_main_n,
   input  logic              en_aux_hi,
   input  logic              en_aux_lo_n,
   input  logic              order_ilv,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              cyc_valid,
   output logic              desel
);
   localparam int HI_W = ADDR_W - BURST_BITS;

   generate
      if (BURST_BITS < 1) begin : g_bad_bb
         $error("BURST_BITS must be at least 1");
      end
      if (ADDR_W <= BURST_BITS) begin : g_bad_aw
         $error("ADDR_W must exceed BURST_BITS");
      end
      if (ORDER_SEL < ORDER_RUNTIME || ORDER_SEL > ORDER_XOR) begin : g_bad_ord
         $error("ORDER_SEL out of range");
      end
   endgenerate

   seq_op_e               op;
   logic [ADDR_W-1:0]     base_q;
   logic [BURST_BITS-1:0] beat_q;
   logic [BURST_BITS-1:0] word_lo;
   logic [HI_W-1:0]       base_hi;

   bas_cmd_decode u_dec (
      .proc_stb_n (proc_stb_n),
      .ctrl_stb_n (ctrl_stb_n),
      .adv_n      (adv_n),
      .en_main_n  (en_main_n),
      .en_aux_hi  (en_aux_hi),
      .en_aux_lo_n(en_aux_lo_n),
      .op         (op)
   );

   bas_beat_reg #(
      .ADDR_W    (ADDR_W),
      .BURST_BITS(BURST_BITS)
   ) u_reg (
      .clk     (clk),
      .rst     (rst),
      .op      (op),
      .ext_addr(ext_addr),
      .base_q  (base_q),
      .beat_q  (beat_q),
      .desel_q (desel),
      .valid_q (cyc_valid)
   );

   bas_order_map #(
      .BURST_BITS(BURST_BITS),
      .ORDER_SEL (ORDER_SEL)
   ) u_map (
      .start_lo (base_q[BURST_BITS-1:0]),
      .beat     (beat_q),
      .order_ilv(order_ilv),
      .word_lo  (word_lo)
   );

   assign base_hi  = base_q[ADDR_W-1:BURST_BITS];
   assign cur_addr = {base_hi, word_lo};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int ADDR_W     = 18,
   parameter int BURST_BITS = 2
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              proc_stb_n,
   input logic              ctrl_stb_n,
   input logic              adv_n,
   input logic              en_main_n,
   input logic              en_aux_hi,
   input logic              en_aux_lo_n,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              cyc_valid,
   input logic              desel
);
   logic aux_ok;
   logic no_strobe;
   assign aux_ok    = en_aux_hi && !en_aux_lo_n;
   assign no_strobe = (proc_stb_n || en_main_n) && ctrl_stb_n;

   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (cur_addr == '0 && desel && !cyc_valid)); // R1
   AST_PROC_LOAD: assert property (@(posedge clk) disable iff (rst)
      (!proc_stb_n && !en_main_n && aux_ok) |=>
         (cur_addr == $past(ext_addr) && cyc_valid && !desel)); // R2
   AST_PROC_AUX_DESEL: assert property (@(posedge clk) disable iff (rst)
      (!proc_stb_n && !en_main_n && !aux_ok) |=> (desel && !cyc_valid)); // R3
   AST_MAIN_OFF_DESEL: assert property (@(posedge clk) disable iff (rst)
      (en_main_n && !ctrl_stb_n) |=> (desel && !cyc_valid)); // R4
   AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
      (proc_stb_n && !ctrl_stb_n && !en_main_n && aux_ok) |=>
         (cur_addr == $past(ext_addr) && cyc_valid && !desel)); // R5
   AST_CTRL_DESEL: assert property (@(posedge clk) disable iff (rst)
      (proc_stb_n && !ctrl_stb_n && !en_main_n && !aux_ok) |=> (desel && !cyc_valid)); // R6
   AST_STEP_HIGH_BITS: assert property (@(posedge clk) disable iff (rst)
      (no_strobe && !adv_n && !desel) |=>
         (cyc_valid && cur_addr[ADDR_W-1:BURST_BITS] == $past(cur_addr[ADDR_W-1:BURST_BITS]))); // R7
   AST_SUSPEND: assert property (@(posedge clk) disable iff (rst)
      (no_strobe && adv_n) |=> (!cyc_valid && $stable(desel))); // R8
   AST_STEP_DESEL: assert property (@(posedge clk) disable iff (rst)
      (no_strobe && !adv_n && desel) |=> (desel && !cyc_valid)); // R12
endmodule

bind burst_addr_seq burst_addr_seq_chk #(
   .ADDR_W    (ADDR_W),
   .BURST_BITS(BURST_BITS)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .ext_addr   (ext_addr),
   .proc_stb_n (proc_stb_n),
   .ctrl_stb_n (ctrl_stb_n),
   .adv_n      (adv_n),
   .en_main_n  (en_main_n),
   .en_aux_hi  (en_aux_hi),
   .en_aux_lo_n(en_aux_lo_n),
   .cur_addr   (cur_addr),
   .cyc_valid  (cyc_valid),
   .desel      (desel)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 18;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] ext_addr = '0;
   logic          proc_stb_n = 1'b1, ctrl_stb_n = 1'b1, adv_n = 1'b1;
   logic          en_main_n = 1'b1, en_aux_hi = 1'b0, en_aux_lo_n = 1'b1;
   logic          order_ilv = 1'b0;
   logic [AW-1:0] cur_addr;
   logic          cyc_valid, desel;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // reference state
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_beat = '0;
   logic          m_desel = 1'b1;
   logic          m_valid = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_addr_seq dut_i (
      .clk(clk), .rst(rst), .ext_addr(ext_addr),
      .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
      .en_main_n(en_main_n), .en_aux_hi(en_aux_hi), .en_aux_lo_n(en_aux_lo_n),
      .order_ilv(order_ilv), .cur_addr(cur_addr), .cyc_valid(cyc_valid), .desel(desel)
   );

   function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] n, logic ilv);
      logic [1:0] lo;
      lo = ilv ? (b[1:0] ^ n) : (b[1:0] + n);
      return {b[AW-1:2], lo};
   endfunction

   function automatic string tag_of(logic p, logic c, logic a, logic m, logic h, logic l, logic ds, logic ilv);
      logic ok;
      ok = h && !l;
      if (!p && !m) return ok ? "R2" : "R3";
      if (!c && m) return "R4";
      if (!c) return ok ? "R5" : "R6";
      if (!p && m) return "R4";
      if (!(ok && !m)) return "R11";
      if (a) return "R8";
      if (ds) return "R12";
      return ilv ? "R10" : "R9";
   endfunction

   task automatic check(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [AW-1:0] ea, input logic p, input logic c, input logic a,
                       input logic m, input logic h, input logic l, input logic ilv);
      string tg;
      logic  ok;
      @(negedge clk);
      ext_addr = ea; proc_stb_n = p; ctrl_stb_n = c; adv_n = a;
      en_main_n = m; en_aux_hi = h; en_aux_lo_n = l; order_ilv = ilv;
      tg = tag_of(p, c, a, m, h, l, m_desel, ilv);
      @(posedge clk);
      ok = h && !l;
      if ((!p && !m) || !c) begin
         if (((!p && !m) || !m) && ok && !m) begin
            m_base = ea; m_beat = '0; m_desel = 1'b0; m_valid = 1'b1;
         end else begin
            m_desel = 1'b1; m_valid = 1'b0;
         end
      end else if (!a) begin
         if (!m_desel) begin m_beat = m_beat + 2'd1; m_valid = 1'b1; end
         else m_valid = 1'b0;
      end else begin
         m_valid = 1'b0;
      end
      #1;
      check(cur_addr == exp_addr(m_base, m_beat, ilv), {tg, " addr"}, cur_addr, exp_addr(m_base, m_beat, ilv));
      check(cyc_valid == m_valid, {tg, " valid"}, AW'(cyc_valid), AW'(m_valid));
      check(desel == m_desel, {tg, " desel"}, AW'(desel), AW'(m_desel));
   endtask

   // loads use all-active enables: main low, aux_hi high, aux_lo_n low
   task automatic burst_run(input logic [AW-1:0] start, input logic ilv, input logic [1:0] exp_lo [5]);
      step(start, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, ilv);
      for (int i = 0; i < 5; i++) begin
         if (i > 0) step('0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, ilv);
         check(cur_addr[1:0] == exp_lo[i], ilv ? "R10 seq" : "R9 seq",
               AW'(cur_addr[1:0]), AW'(exp_lo[i]));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [1:0] lin_seq [5];
      logic [1:0] ilv_seq [5];
      void'($urandom(32'd5150));
      lin_seq = '{2'b01, 2'b10, 2'b11, 2'b00, 2'b01};
      ilv_seq = '{2'b10, 2'b11, 2'b00, 2'b01, 2'b10};
      repeat (2) @(posedge clk);
      #1;
      check(cur_addr == '0 && desel && !cyc_valid, "R1 reset", cur_addr, '0);
      @(negedge clk); rst = 1'b0;

      // R12: step while still deselected
      step('0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
      // R9 and R10 directed sequences, wrap included
      burst_run(18'h2A5C1, 1'b0, lin_seq);
      burst_run(18'h1F0E2, 1'b1, ilv_seq);
      // R8 suspend, R11 enable noise on suspend and step
      step('1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
      step('1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      // R4 processor strobe ignored with main enable off
      step(18'h00007, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      step(18'h00007, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      // R5 controller load, R6 controller deselect, R3 processor deselect
      step(18'h3C003, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      step(18'h11111, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      step(18'h3C003, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      step(18'h22222, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);

      for (int k = 0; k < 4000; k++) begin
         logic [AW-1:0] ea;
         logic p, c, a, m, h, l, ilv;
         ea  = AW'($urandom);
         p   = ($urandom % 4) != 0;
         c   = ($urandom % 4) != 0;
         a   = ($urandom % 3) == 0;
         m   = ($urandom % 5) == 0;
         h   = ($urandom % 5) != 0;
         l   = ($urandom % 5) == 0;
         ilv = (k / 500) % 2 == 1;
         step(ea, p, c, a, m, h, l, ilv);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule